// File: doc/BRIEF.md
# Flash Program/Erase Pulse Sequencer

This block produces the control levels that an embedded non-volatile memory array needs while a word is programmed, a page is erased or the whole module is erased. A host writes a clock prescaler and a set of phase counts through a small write port, then issues a one-cycle start with an operation code. The sequencer raises the program or erase enable, waits a setup time, raises the storage-enable strobe, optionally waits a transfer time, holds the high-voltage pulse, drops the enable, holds the storage strobe, drops it, and waits out a recovery time before it returns to idle and flags completion.

Every phase lasts (prescale+1) × scale × (count+1) system clocks. The scale is 1 for setup, transfer, normal hold and recovery. It is 8 for the program pulse and for the module-erase hold, and 4096 for both erase pulses. All timing values are captured when an operation is accepted. A cumulative counter tracks how many clocks of program pulse a row has seen since its last erase and raises a flag once a programmable ceiling is passed.

Top module: `nvm_pulse_seq`

## Requirements
- R1: A synchronous reset, also when it arrives mid-operation, drives every strobe, busy, done, the error flag and the stress flag low. It returns all timing registers to zero and the stress ceiling to all ones.
- R2: Operation code 0 (word program) produces these phases in order, with D as the prescale value:
  - prog_en alone for (D+1)(S+1) clocks;
  - prog_en with nvstr for (D+1)(T+1) clocks;
  - prog_en, nvstr and pulse for (D+1)·8·(P+1) clocks;
  - nvstr alone for (D+1)(H+1) clocks;
  - busy alone for (D+1)(V+1) clocks.
- R3: Operation code 1 (page erase) uses erase_en and has no transfer phase. It runs setup (D+1)(S+1), then pulse (D+1)·4096·(E+1) with the page-erase count E, then hold (D+1)(H+1), then recovery (D+1)(V+1).
- R4: Operation code 2 (module erase) behaves as in R3 but takes the module-erase count M for the pulse, (D+1)·4096·(M+1). Its hold lasts (D+1)·8·(K+1), where K is the module hold count.
- R5: Each phase length scales by the prescale value plus one.
- R6: done rises for exactly one clock, in the first clock in which busy is low after an operation.
- R7: A start while busy is ignored, leaves the running operation unchanged, and sets a sticky error flag.
- R8: Timing register writes made during an operation do not alter it and take effect from the next operation.
- R9: Operation code 3 is reserved. A start with it launches nothing and sets the sticky error flag.
- R10: Clocks with prog_en and pulse both high accumulate. The stress flag is high while the total exceeds the ceiling. Accepting either erase clears both the total and the flag.
- R11: prog_en and erase_en are never high together, pulse is high only with nvstr, and nvstr rises only after an enable has already been high.
- R12: Register write addresses are:
  - 0: prescale;
  - 1: setup S;
  - 2: transfer T;
  - 3: program P;
  - 4: page erase E;
  - 5: module erase M;
  - 6: hold H;
  - 7: module hold K;
  - 8: recovery V;
  - 9: stress ceiling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register write address |
| cfg_wdata | input | BUS_W | Register write data, truncated to field width |
| start_i | input | 1 | Start request, one clock |
| op_i | input | 2 | Operation code presented with start |
| prog_en_o | output | 1 | Program enable |
| erase_en_o | output | 1 | Erase enable |
| nvstr_o | output | 1 | Storage-enable strobe |
| pulse_o | output | 1 | High-voltage pulse window |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-clock completion pulse |
| seq_err_o | output | 1 | Sticky rejected-start flag |
| over_stress_o | output | 1 | Program exposure above ceiling |

## Verification
The bench builds the block with a 4-bit prescaler, 6-bit phase counts, a 12-bit stress total and a 16-bit write bus. These narrow fields keep full erase pulses near 4096 clocks, so both erase kinds, two prescale settings and a ceiling crossing fit in one short run. The small ceiling of 20 lets two program operations push the total over the limit before an erase brings it back to zero.

// File: rtl/nvm_seq_pkg.sv
package nvm_seq_pkg;

  typedef enum logic [1:0] {
    OP_PROG   = 2'd0,
    OP_PERASE = 2'd1,
    OP_MERASE = 2'd2,
    OP_RSV    = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_TRAN  = 3'd2,
    ST_PULSE = 3'd3,
    ST_HOLD  = 3'd4,
    ST_RECOV = 3'd5
  } state_e;

  // indices into the phase count array
  localparam int CI_SETUP  = 0;
  localparam int CI_TRAN   = 1;
  localparam int CI_PROG   = 2;
  localparam int CI_PERASE = 3;
  localparam int CI_MERASE = 4;
  localparam int CI_HOLD   = 5;
  localparam int CI_MHOLD  = 6;
  localparam int CI_RECOV  = 7;
  localparam int NCNT      = 8;

  // write addresses: count i sits at CNT_BASE+i
  localparam logic [3:0] ADDR_DIV   = 4'd0;
  localparam int         CNT_BASE   = 1;
  localparam logic [3:0] ADDR_LIMIT = 4'd9;

  // scale exponents
  localparam logic [3:0] SH_UNIT  = 4'd0;
  localparam logic [3:0] SH_EIGHT = 4'd3;
  localparam logic [3:0] SH_ERASE = 4'd12;
  localparam int         SH_MAX   = 12;

endpackage

// File: rtl/nvm_cfg_regs.sv
module nvm_cfg_regs
  import nvm_seq_pkg::*;
#(
  parameter int DW    = 8,
  parameter int CW    = 8,
  parameter int SW    = 16,
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we_i,
  input  logic [3:0]       addr_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [DW-1:0]    div_o,
  output logic [CW-1:0]    cnt_o [NCNT],
  output logic [SW-1:0]    limit_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_o <= '0;
    end else if (we_i && addr_i == ADDR_DIV) begin
      div_o <= wdata_i[DW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      limit_o <= '1;
    end else if (we_i && addr_i == ADDR_LIMIT) begin
      limit_o <= wdata_i[SW-1:0];
    end
  end

  for (genvar gi = 0; gi < NCNT; gi++) begin : g_cnt
    localparam logic [3:0] MY_ADDR = 4'(CNT_BASE + gi);
    always_ff @(posedge clk) begin
      if (rst) begin
        cnt_o[gi] <= '0;
      end else if (we_i && addr_i == MY_ADDR) begin
        cnt_o[gi] <= wdata_i[CW-1:0];
      end
    end
  end

endmodule

// File: rtl/nvm_phase_timer.sv
module nvm_phase_timer #(
  parameter int DW = 8,
  parameter int UW = 21
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic [DW-1:0] div_i,
  input  logic [UW-1:0] last_i,
  output logic          fin_o
);

  logic [DW-1:0] pre_q;
  logic [UW-1:0] unit_q;
  logic          pre_wrap;

  assign pre_wrap = (pre_q == div_i);
  assign fin_o    = pre_wrap && (unit_q == last_i);

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      pre_q  <= '0;
      unit_q <= '0;
    end else if (pre_wrap) begin
      pre_q  <= '0;
      unit_q <= unit_q + UW'(1);
    end else begin
      pre_q <= pre_q + DW'(1);
    end
  end

  // R5
  unit_bound_chk: assert property (@(posedge clk) disable iff (rst)
    unit_q <= last_i);

  // R5
  pre_bound_chk: assert property (@(posedge clk) disable iff (rst)
    pre_q <= div_i);

endmodule

// File: rtl/nvm_stress_meter.sv
module nvm_stress_meter #(
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc_i,
  input  logic          clr_i,
  input  logic [SW-1:0] limit_i,
  output logic          over_o
);

  logic [SW-1:0] tot_q;
  logic [SW-1:0] tot_d;

  always_comb begin
    tot_d = tot_q;
    if (clr_i) begin
      tot_d = '0;
    end else if (inc_i && tot_q != '1) begin
      tot_d = tot_q + SW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tot_q  <= '0;
      over_o <= 1'b0;
    end else begin
      tot_q  <= tot_d;
      over_o <= (tot_d > limit_i);
    end
  end

  // R10
  erase_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> !over_o);

endmodule

// File: rtl/nvm_pulse_seq.sv
module nvm_pulse_seq
  import nvm_seq_pkg::*;
#(
  parameter int DW    = 8,
  parameter int CW    = 8,
  parameter int SW    = 16,
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [3:0]       cfg_addr,
  input  logic [BUS_W-1:0] cfg_wdata,
  input  logic             start_i,
  input  logic [1:0]       op_i,
  output logic             prog_en_o,
  output logic             erase_en_o,
  output logic             nvstr_o,
  output logic             pulse_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             seq_err_o,
  output logic             over_stress_o
);

  localparam int UW = CW + SH_MAX + 1;

  logic [DW-1:0] cfg_div;
  logic [CW-1:0] cfg_cnt [NCNT];
  logic [SW-1:0] cfg_limit;

  nvm_cfg_regs #(.DW(DW), .CW(CW), .SW(SW), .BUS_W(BUS_W)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .we_i    (cfg_we),
    .addr_i  (cfg_addr),
    .wdata_i (cfg_wdata),
    .div_o   (cfg_div),
    .cnt_o   (cfg_cnt),
    .limit_o (cfg_limit)
  );

  state_e        st, nxt;
  op_e           snap_op, op_eff, op_req;
  logic [DW-1:0] snap_div;
  logic [CW-1:0] snap_cnt [NCNT];
  logic          accept, reject;
  logic          tmr_clr, tmr_fin;
  logic [CW-1:0] base;
  logic [3:0]    sh;
  logic [UW-1:0] last;

  assign op_req = op_e'(op_i);
  assign accept = start_i && (st == ST_IDLE) && (op_req != OP_RSV);
  assign reject = start_i && !accept;
  assign op_eff = accept ? op_req : snap_op;

  // phase target in prescaled units, minus one
  always_comb begin
    base = '0;
    sh   = SH_UNIT;
    unique case (st)
      ST_SETUP: base = snap_cnt[CI_SETUP];
      ST_TRAN:  base = snap_cnt[CI_TRAN];
      ST_PULSE: begin
        unique case (snap_op)
          OP_PERASE: begin base = snap_cnt[CI_PERASE]; sh = SH_ERASE; end
          OP_MERASE: begin base = snap_cnt[CI_MERASE]; sh = SH_ERASE; end
          default:   begin base = snap_cnt[CI_PROG];   sh = SH_EIGHT; end
        endcase
      end
      ST_HOLD: begin
        if (snap_op == OP_MERASE) begin
          base = snap_cnt[CI_MHOLD];
          sh   = SH_EIGHT;
        end else begin
          base = snap_cnt[CI_HOLD];
        end
      end
      ST_RECOV: base = snap_cnt[CI_RECOV];
      default:  base = '0;
    endcase
  end

  assign last    = ((UW'(base) + UW'(1)) << sh) - UW'(1);
  assign tmr_clr = (st == ST_IDLE) || tmr_fin;

  nvm_phase_timer #(.DW(DW), .UW(UW)) u_tmr (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (tmr_clr),
    .div_i  (snap_div),
    .last_i (last),
    .fin_o  (tmr_fin)
  );

  always_comb begin
    nxt = st;
    unique case (st)
      ST_IDLE:  if (accept) nxt = ST_SETUP;
      ST_SETUP: if (tmr_fin) nxt = (snap_op == OP_PROG) ? ST_TRAN : ST_PULSE;
      ST_TRAN:  if (tmr_fin) nxt = ST_PULSE;
      ST_PULSE: if (tmr_fin) nxt = ST_HOLD;
      ST_HOLD:  if (tmr_fin) nxt = ST_RECOV;
      ST_RECOV: if (tmr_fin) nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  logic en_phase;
  assign en_phase = (nxt == ST_SETUP) || (nxt == ST_TRAN) || (nxt == ST_PULSE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      prog_en_o  <= 1'b0;
      erase_en_o <= 1'b0;
      nvstr_o    <= 1'b0;
      pulse_o    <= 1'b0;
      busy_o     <= 1'b0;
      done_o     <= 1'b0;
      seq_err_o  <= 1'b0;
    end else begin
      st         <= nxt;
      prog_en_o  <= en_phase && (op_eff == OP_PROG);
      erase_en_o <= en_phase && (op_eff != OP_PROG);
      nvstr_o    <= (nxt == ST_TRAN) || (nxt == ST_PULSE) || (nxt == ST_HOLD);
      pulse_o    <= (nxt == ST_PULSE);
      busy_o     <= (nxt != ST_IDLE);
      done_o     <= (st == ST_RECOV) && tmr_fin;
      seq_err_o  <= seq_err_o || reject;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_op  <= OP_PROG;
      snap_div <= '0;
      snap_cnt <= '{default: '0};
    end else if (accept) begin
      snap_op  <= op_req;
      snap_div <= cfg_div;
      snap_cnt <= cfg_cnt;
    end
  end

  nvm_stress_meter #(.SW(SW)) u_stress (
    .clk     (clk),
    .rst     (rst),
    .inc_i   (prog_en_o && pulse_o),
    .clr_i   (accept && (op_req != OP_PROG)),
    .limit_i (cfg_limit),
    .over_o  (over_stress_o)
  );

  // R11
  excl_enable_chk: assert property (@(posedge clk) disable iff (rst)
    !(prog_en_o && erase_en_o));

  // R11
  pulse_in_store_chk: assert property (@(posedge clk) disable iff (rst)
    pulse_o |-> (nvstr_o && busy_o));

  // R2
  setup_first_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(nvstr_o) |-> $past(prog_en_o || erase_en_o));

  // R6
  done_edge_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && $past(busy_o)));

  // R7
  busy_start_err_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && busy_o) |=> seq_err_o);

  // R8
  snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> ($stable(snap_div) && $stable(snap_op)));

endmodule

// File: tb/nvm_pulse_seq_test.sv
module nvm_pulse_seq_test;

  localparam int DW = 4;
  localparam int CW = 6;
  localparam int SW = 12;
  localparam int BUS_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cfg_we = 1'b0;
  logic [3:0]       cfg_addr = '0;
  logic [BUS_W-1:0] cfg_wdata = '0;
  logic             start_i = 1'b0;
  logic [1:0]       op_i = '0;
  logic prog_en_o, erase_en_o, nvstr_o, pulse_o, busy_o, done_o, seq_err_o, over_stress_o;

  nvm_pulse_seq #(.DW(DW), .CW(CW), .SW(SW), .BUS_W(BUS_W)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .start_i(start_i), .op_i(op_i), .prog_en_o(prog_en_o), .erase_en_o(erase_en_o),
    .nvstr_o(nvstr_o), .pulse_o(pulse_o), .busy_o(busy_o), .done_o(done_o),
    .seq_err_o(seq_err_o), .over_stress_o(over_stress_o)
  );

  always #2.5 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // segment vector: {prog_en, erase_en, nvstr, pulse, busy}
  logic [4:0] exp_v [$];
  int         exp_n [$];
  logic [4:0] prv = '0;
  int         run = 0;
  logic       prv_busy = 1'b0;
  bit         mon_en = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops expected phase segments and compares
  always @(negedge clk) begin
    if (!mon_en) begin
      prv = '0; run = 0; prv_busy = 1'b0;
    end else begin
      logic [4:0] v;
      v = {prog_en_o, erase_en_o, nvstr_o, pulse_o, busy_o};
      if (v != prv) begin
        if (prv != '0) begin
          if (exp_v.size() == 0) begin
            check(0, "R2/R3/R4 unexpected segment", int'(prv), 0);
          end else begin
            logic [4:0] ev;
            int en;
            ev = exp_v.pop_front();
            en = exp_n.pop_front();
            check(ev == prv, "R2/R3/R4/R11 phase levels", int'(prv), int'(ev));
            check(en == run, "R2/R3/R4/R5 phase length", run, en);
          end
        end
        prv = v;
        run = 1;
      end else begin
        run++;
      end
      if (prv_busy && !busy_o) check(done_o == 1'b1, "R6 done at busy fall", done_o, 1);
      else if (done_o) check(0, "R6 stray done", 1, 0);
      prv_busy = busy_o;
    end
  end

  task automatic cfg_wr(input logic [3:0] a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = BUS_W'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic push_op(input int op, input int ls, input int lt, input int lp,
                         input int lh, input int lr);
    logic [4:0] en;
    en = (op == 0) ? 5'b10001 : 5'b01001;
    exp_v.push_back(en);          exp_n.push_back(ls);
    if (op == 0) begin
      exp_v.push_back(en | 5'b00100); exp_n.push_back(lt);
    end
    exp_v.push_back(en | 5'b00110); exp_n.push_back(lp);
    exp_v.push_back(5'b00101);      exp_n.push_back(lh);
    exp_v.push_back(5'b00001);      exp_n.push_back(lr);
  endtask

  task automatic kick(input int op);
    @(negedge clk);
    start_i = 1'b1; op_i = 2'(op);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    while (busy_o) @(negedge clk);
    @(negedge clk);
    check(exp_v.size() == 0, req, exp_v.size(), 0);
  endtask

  task automatic run_op(input int op, input int ls, input int lt, input int lp,
                        input int lh, input int lr, input string req);
    push_op(op, ls, lt, lp, lh, lr);
    kick(op);
    wait_idle(req);
  endtask

  initial begin
    #500000;
    if (!finished) begin
      finished = 1;
      check(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 outputs quiet in reset
    check({prog_en_o, erase_en_o, nvstr_o, pulse_o, busy_o, done_o, seq_err_o, over_stress_o} == 8'd0,
          "R1 reset outputs", 0, 0);
    rst = 1'b0;
    mon_en = 1;

    // R12 register map
    cfg_wr(4'd1, 1);  // setup S
    cfg_wr(4'd2, 2);  // transfer T
    cfg_wr(4'd3, 0);  // program P
    cfg_wr(4'd4, 0);  // page erase E
    cfg_wr(4'd5, 0);  // module erase M
    cfg_wr(4'd6, 3);  // hold H
    cfg_wr(4'd7, 1);  // module hold K
    cfg_wr(4'd8, 4);  // recovery V
    cfg_wr(4'd9, 20); // ceiling

    // R2 program, prescale 0
    run_op(0, 2, 3, 8, 4, 5, "R2 program sequence complete");
    check(over_stress_o == 1'b0, "R10 below ceiling", over_stress_o, 0);

    // R5 prescale 2
    cfg_wr(4'd0, 2);
    run_op(0, 6, 9, 24, 12, 15, "R5 prescaled program complete");
    check(over_stress_o == 1'b1, "R10 above ceiling", over_stress_o, 1);
    cfg_wr(4'd0, 0);

    // R3 page erase; R10 flag clears on acceptance
    push_op(1, 2, 0, 4096, 4, 5);
    kick(1);
    check(over_stress_o == 1'b0, "R10 erase clears flag", over_stress_o, 0);
    wait_idle("R3 page erase complete");

    // R4 module erase
    run_op(2, 2, 0, 4096, 16, 5, "R4 module erase complete");
    check(seq_err_o == 1'b0, "R7 no error yet", seq_err_o, 0);

    // R7 start while busy, R8 write during operation
    push_op(0, 2, 3, 8, 4, 5);
    kick(0);
    repeat (3) @(negedge clk);
    start_i = 1'b1; op_i = 2'd2;
    @(negedge clk);
    start_i = 1'b0;
    check(seq_err_o == 1'b1, "R7 sticky error set", seq_err_o, 1);
    cfg_wr(4'd3, 3);
    wait_idle("R7/R8 running operation unchanged");
    check(seq_err_o == 1'b1, "R7 error stays set", seq_err_o, 1);

    // R8 new count applies to the next operation
    run_op(0, 2, 3, 32, 4, 5, "R8 new program count applied");

    // R1 mid-operation reset
    mon_en = 0;
    kick(0);
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check({prog_en_o, erase_en_o, nvstr_o, pulse_o, busy_o, done_o, seq_err_o, over_stress_o} == 8'd0,
          "R1 mid-operation reset", 1, 0);
    rst = 1'b0;
    @(negedge clk);
    mon_en = 1;
    @(negedge clk);

    // R1 timing registers back to zero
    run_op(0, 1, 1, 8, 1, 1, "R1 zeroed timing registers");

    // R9 reserved code
    kick(3);
    repeat (4) @(negedge clk);
    check(busy_o == 1'b0, "R9 reserved op launches nothing", busy_o, 0);
    check(seq_err_o == 1'b1, "R9 reserved op sets error", seq_err_o, 1);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule